// File: doc/BRIEF.md
# Per-Pin Multiplexed Bidirectional I/O Port

This block drives seven bidirectional pads. Each pad works either as a plain port pin or carries an internal control signal to the outside. In port use, a per-bit direction register decides whether the pad is driven from the output latch or left released as an input. A per-bit function register, qualified by a global strap input, hands a pad over to its control signal. While a pad is handed over, it is always driven.

Software reaches the data latch, the direction register and the function register through a small 8-bit register bus. Every register holds only seven meaningful bits. On a write, the top bus bit is dropped. On a read, the top bus bit comes back as zero. Pad levels pass through a two-stage synchronizer before they can be read, so a pad change appears on a data read two clocks later.

Top module: `mux_io_port`

## Requirements
- R1: During reset and on the first cycle after it, every pad is released (padOe all zero), and all three registers read back as zero.
- R2: A write with busAddr=1 loads the direction register from busWdata[6:0] on that clock edge. In port use, pad i is driven (padOe[i]=1) exactly when direction bit i is 1, and it then outputs output-latch bit i.
- R3: Pad i is in control use exactly when modeStrap is 1 and function-register bit i is 1. In control use, padOe[i]=1 and padOut[i]=altOut[i], whatever the direction bit.
- R4: A write with busAddr=0 loads the output latch from busWdata[6:0]. A read at address 0 returns latch bit i for every pad that is in port use with direction 1.
- R5: For a pad that is an input or in control use, bit i of a read at address 0 returns padIn[i] as it was two clock edges earlier (two-flop synchronizer).
- R6: busWdata[7] is ignored on every write, and busRdata[7] is always 0.
- R7: Address 3 holds no register: a write there changes no register and no pad, and a read there returns 0.
- R8: With modeStrap at 0, every pad stays in port use whatever the function register holds, and the function register (busAddr=2) still reads back the value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeStrap | input | 1 | Global enable for control use |
| busAddr | input | 2 | Register select: 0 latch, 1 direction, 2 function, 3 none |
| busWrEn | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the register at busAddr (combinational) |
| altOut | input | 7 | Internal control signals, one per pad |
| padIn | input | 7 | Pad input levels |
| padOut | output | 7 | Pad output values |
| padOe | output | 7 | Pad output enables, 1 = drive |

## Verification
The assertions check on every cycle that control-use pads are driven with their control signal, that a low strap leaves each pad on its latch, that the top read bit is zero, and that direction writes land. They also check that address 3 is inert and that pads are released after reset. What a read returns for an input pad, including the two-clock synchronizer delay, and how mixed per-bit direction and function settings combine can only be shown by the bench. The bench compares the pads and the read data against its behavioural model on every clock.

// File: rtl/mux_io_pkg.sv
`timescale 1ns/1ps
package mux_io_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_LATCH = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_FUNC  = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_t;

  typedef struct packed {
    logic wrLatch;
    logic wrDir;
    logic wrFunc;
  } ctrlStrb_t;
endpackage

// File: rtl/mux_io_sync.sv
`timescale 1ns/1ps
module mux_io_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/mux_io_ctrl.sv
`timescale 1ns/1ps
module mux_io_ctrl
  import mux_io_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrb_t         strb,
  output regSel_t           rdSel
);
  always_comb begin
    rdSel = regSel_t'(busAddr);
    strb  = '0;
    if (busWrEn) begin
      unique case (rdSel)
        SEL_LATCH: strb.wrLatch = 1'b1;
        SEL_DIR:   strb.wrDir   = 1'b1;
        SEL_FUNC:  strb.wrFunc  = 1'b1;
        SEL_NONE:  strb         = '0;
      endcase
    end
  end
endmodule

// File: rtl/mux_io_datapath.sv
`timescale 1ns/1ps
module mux_io_datapath
  import mux_io_pkg::*;
#(
  parameter int WIDTH       = 7,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  regSel_t          rdSel,
  input  logic [BUS_W-1:0] wrData,
  input  logic             modeStrap,
  input  logic [WIDTH-1:0] altOut,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [BUS_W-1:0] rdData,
  output logic [WIDTH-1:0] latchQ,
  output logic [WIDTH-1:0] dirQ,
  output logic [WIDTH-1:0] funcQ
);
  localparam int PAD_W = BUS_W - WIDTH;

  logic [WIDTH-1:0] padSync;
  logic [WIDTH-1:0] altSel;
  logic [WIDTH-1:0] latchView;
  logic [WIDTH-1:0] rdBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '0;
      funcQ  <= '0;
    end else begin
      if (strb.wrLatch) latchQ <= wrData[WIDTH-1:0];
      if (strb.wrDir)   dirQ   <= wrData[WIDTH-1:0];
      if (strb.wrFunc)  funcQ  <= wrData[WIDTH-1:0];
    end
  end

  mux_io_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (padIn),
    .syncOut (padSync)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign altSel[i]    = modeStrap & funcQ[i];
    assign padOut[i]    = altSel[i] ? altOut[i] : latchQ[i];
    assign padOe[i]     = altSel[i] | dirQ[i];
    assign latchView[i] = (dirQ[i] & ~altSel[i]) ? latchQ[i] : padSync[i];
  end

  always_comb begin
    unique case (rdSel)
      SEL_LATCH: rdBits = latchView;
      SEL_DIR:   rdBits = dirQ;
      SEL_FUNC:  rdBits = funcQ;
      SEL_NONE:  rdBits = '0;
    endcase
    rdData = {{PAD_W{1'b0}}, rdBits};
  end
endmodule

// File: rtl/mux_io_port.sv
`timescale 1ns/1ps
module mux_io_port
  import mux_io_pkg::*;
#(
  parameter int WIDTH       = 7,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeStrap,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [WIDTH-1:0]  altOut,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe
);
  ctrlStrb_t        strb;
  regSel_t          rdSel;
  logic [WIDTH-1:0] latchQ;
  logic [WIDTH-1:0] dirQ;
  logic [WIDTH-1:0] funcQ;

  mux_io_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  mux_io_datapath #(.WIDTH(WIDTH), .BUS_W(BUS_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rdSel     (rdSel),
    .wrData    (busWdata),
    .modeStrap (modeStrap),
    .altOut    (altOut),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .rdData    (busRdata),
    .latchQ    (latchQ),
    .dirQ      (dirQ),
    .funcQ     (funcQ)
  );
endmodule

// File: rtl/mux_io_port_chk.sv
`timescale 1ns/1ps
module mux_io_port_chk #(
  parameter int WIDTH = 7,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeStrap,
  input logic [1:0]       busAddr,
  input logic             busWrEn,
  input logic [BUS_W-1:0] busWdata,
  input logic [BUS_W-1:0] busRdata,
  input logic [WIDTH-1:0] altOut,
  input logic [WIDTH-1:0] padOut,
  input logic [WIDTH-1:0] padOe,
  input logic [WIDTH-1:0] latchQ,
  input logic [WIDTH-1:0] dirQ,
  input logic [WIDTH-1:0] funcQ
);
  p_released_after_reset_r1: assert property (@(posedge clk)
    !rstN |=> (padOe == '0));

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd1) |=> (dirQ == $past(busWdata[WIDTH-1:0])));

  p_input_released_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!modeStrap && dirQ == '0) |-> (padOe == '0));

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    p_ctrl_drive_r3: assert property (@(posedge clk) disable iff (!rstN)
      (modeStrap && funcQ[i]) |-> (padOe[i] && padOut[i] == altOut[i]));
  end

  p_top_bit_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[BUS_W-1] == 1'b0);

  p_hole_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd3) |-> (busRdata == '0));

  p_hole_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd3) |=> ($stable(latchQ) && $stable(dirQ) && $stable(funcQ)));

  p_strap_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !modeStrap |-> (padOut == latchQ));
endmodule

bind mux_io_port mux_io_port_chk #(.WIDTH(WIDTH), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modeStrap (modeStrap),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .altOut    (altOut),
  .padOut    (padOut),
  .padOe     (padOe),
  .latchQ    (latchQ),
  .dirQ      (dirQ),
  .funcQ     (funcQ)
);

// File: tb/tb_mux_io_port.sv
`timescale 1ns/1ps
module tb_mux_io_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeStrap = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic [6:0] altOut = 7'd0;
  logic [6:0] padIn = 7'd0;
  logic [6:0] padOut;
  logic [6:0] padOe;

  int testsRun = 0;
  int testsFailed = 0;
  bit compareOn = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  int mLatch = 0, mDir = 0, mFunc = 0;
  int syncQ[$] = '{0, 0};

  always #2.5 clk = ~clk;

  mux_io_port dut (
    .clk(clk), .rstN(rstN), .modeStrap(modeStrap), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWdata(busWdata), .busRdata(busRdata),
    .altOut(altOut), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mLatch = 0; mDir = 0; mFunc = 0;
      syncQ = '{0, 0};
    end else begin
      void'(syncQ.pop_front());
      syncQ.push_back(int'(padIn));
      if (busWrEn) begin
        case (busAddr)
          2'd0: mLatch = busWdata % 128;
          2'd1: mDir   = busWdata % 128;
          2'd2: mFunc  = busWdata % 128;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expAlt();
    return modeStrap ? mFunc : 0;
  endfunction

  function automatic int expOe();
    return mDir | expAlt();
  endfunction

  function automatic int expOut();
    int r = 0;
    for (int i = 0; i < 7; i++) begin
      if ((expAlt() >> i) & 1) r |= ((altOut >> i) & 1) << i;
      else                     r |= ((mLatch >> i) & 1) << i;
    end
    return r;
  endfunction

  function automatic int expRead();
    int r = 0;
    case (busAddr)
      2'd0: for (int i = 0; i < 7; i++) begin
              if (((mDir >> i) & 1) && !((expAlt() >> i) & 1)) r |= ((mLatch >> i) & 1) << i;
              else                                              r |= ((syncQ[0] >> i) & 1) << i;
            end
      2'd1: r = mDir;
      2'd2: r = mFunc;
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic compareAll();
    check(int'(padOe) == expOe(), "R2/R3 padOe", int'(padOe), expOe());
    check(int'(padOut) == expOut(), "R3/R4 padOut", int'(padOut), expOut());
    check(int'(busRdata) == expRead(), "R4/R5 busRdata", int'(busRdata), expRead());
  endtask

  task automatic tick();
    @(negedge clk);
    if (compareOn) compareAll();
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, input int exp, input string tag);
    busAddr = a;
    #0.5;
    check(int'(busRdata) == exp, tag, int'(busRdata), exp);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compareOn = 1'b1;
    tick();
    check(padOe == 7'd0, "R1 reset padOe", int'(padOe), 0);
    rstN = 1'b1;
    tick();
    check(padOe == 7'd0, "R1 post-reset padOe", int'(padOe), 0);
    peek(2'd0, 0, "R1 latch read");
    peek(2'd1, 0, "R1 dir read");
    peek(2'd2, 0, "R1 func read");

    // R6: top bit dropped on writes, zero on reads
    busWrite(2'd0, 8'hAA);
    busWrite(2'd1, 8'hFF);
    peek(2'd1, 8'h7F, "R6 dir read top bit");
    peek(2'd0, 8'h2A, "R4 latch readback");
    check(padOe == 7'h7F, "R2 all driven", int'(padOe), 'h7F);
    check(padOut == 7'h2A, "R4 pad drives latch", int'(padOut), 'h2A);

    // R5: input pins read synchronized pads
    busWrite(2'd1, 8'h0F);
    padIn = 7'h50;
    busAddr = 2'd0;
    tick();
    check(busRdata[6:4] == 3'b000, "R5 one edge not yet visible", int'(busRdata[6:4]), 0);
    tick();
    check(busRdata == 8'h5A, "R5 two edges visible", int'(busRdata), 'h5A);

    // R7: address 3 is inert
    busWrite(2'd3, 8'hFF);
    peek(2'd3, 0, "R7 hole read");
    peek(2'd1, 8'h0F, "R7 dir unchanged");
    peek(2'd0, 8'h5A, "R7 latch unchanged");

    // R8: strap low keeps port use
    modeStrap = 1'b0;
    altOut = 7'h7F;
    busWrite(2'd2, 8'hD5);
    peek(2'd2, 8'h55, "R8 func readback");
    check(padOut == 7'h2A, "R8 strap low pads on latch", int'(padOut), 'h2A);

    // R3: strap high hands function bits over
    modeStrap = 1'b1;
    tick();
    check(padOe == 7'h5F, "R3 control forces drive", int'(padOe), 'h5F);
    check(padOut == 7'h7F, "R3 control drives altOut", int'(padOut), 'h7F);
    altOut = 7'h00;
    tick();
    check(padOut == 7'h2A, "R3 altOut low", int'(padOut), 'h2A);

    // mixed random traffic, model compared every clock
    for (int n = 0; n < 400; n++) begin
      busAddr   = 2'($urandom_range(0, 3));
      busWrEn   = 1'($urandom_range(0, 1));
      busWdata  = 8'($urandom);
      padIn     = 7'($urandom);
      altOut    = 7'($urandom);
      modeStrap = 1'($urandom_range(0, 1));
      tick();
    end
    busWrEn = 1'b0;
    rstN = 1'b0;
    tick();
    tick();
    check(padOe == 7'd0, "R1 re-reset padOe", int'(padOe), 0);
    finished = 1'b1;
    report();
  end
endmodule